// File: doc/BRIEF.md
# Staggered Power-Good Sequencer with Cascaded Enables

This block drives four active-low power-good lines that switch on downstream converters one after another once the main pass switch has been confirmed on. The first line asserts as soon as the switch-on permission is present. Each later line follows the one before it after a programmable gap. The gap is measured in ticks of an external microsecond strobe. A 3-bit code picks the tick count from a parameter table.

Each line has a data value and an output enable. A hierarchy of enable inputs can tri-state whole groups of later lines. Enable A covers lines 2 to 4, enable B covers lines 3 and 4, and enable C covers line 4. A mode bit turns the forced-shutdown pin into a fourth enable for line 1. A second option decides whether that pin also governs lines 2 to 4. When an enable comes back while the switch is still on, the lines it covers start their stage delays again. Loss of the switch-on permission releases every line in the same cycle.

Top module: `pg_sequencer`

## Requirements
- R1: While reset is held and after it is released with switch-on low, all four power-good data bits read 1 (inactive) and all four output enables read 1.
- R2: Line 1 (bit 0) asserts low on the first clock edge at which switch-on is high and line 1's enable is true.
- R3: Line k+1 asserts exactly N ticks after line k has asserted, where N is the table entry for the delay code. With the tick held high, that is N clock edges after the edge on which line k asserted.
- R4: The 3-bit delay code indexes the tick-count table. Code 1 and code 4 select different entries, and the gap follows the code that is applied.
- R5: While us_tick is low, a pending stage delay does not advance. The assertion moves later by the number of cycles without a tick.
- R6: When switch-on falls, all power-good data bits return to 1 in that same cycle, and all lines start from line 1 when it returns.
- R7: Enable A low clears the output enables of lines 2 to 4 in the same cycle. Line 1 stays asserted.
- R8: Enable B low disables lines 3 and 4. Enable C low disables line 4 only. A disabled line carries data 1.
- R9: When an enable reasserts while switch-on is high, the first line it covers restarts its full stage delay from that cycle. Later lines follow in order.
- R10: With fs_as_enable=1 and pg1_gates_rest=0, fs_n low tri-states line 1 only. Line 1 reasserts one edge after fs_n returns high.
- R11: With fs_as_enable=1 and pg1_gates_rest=1, fs_n low tri-states all four lines. When it returns, the whole stagger runs again from line 1.
- R12: With fs_as_enable=0, fs_n has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond strobe that paces the stage delays |
| switch_on | input | 1 | Permission: pass switch confirmed on |
| en_a | input | 1 | Enable for lines 2–4 (active high) |
| en_b | input | 1 | Enable for lines 3–4 (active high) |
| en_c | input | 1 | Enable for line 4 (active high) |
| fs_n | input | 1 | Forced-shutdown pin, read as an enable when fs_as_enable is set |
| fs_as_enable | input | 1 | Use fs_n as the enable of line 1 |
| pg1_gates_rest | input | 1 | With fs_as_enable, fs_n also gates lines 2–4 |
| dly_sel | input | 3 | Stage delay code, index into the tick-count table |
| pg_n_o | output | 4 | Power-good data, active low, bit 0 is line 1 |
| pg_oe_o | output | 4 | Output enable per line; 0 means high impedance |

## Verification
The hardest case to reach is a restart in the middle of a sequence. Some lines must already be asserted, an enable must drop and return, and the re-timed stage must be watched while an earlier line stays on. The stimulus gets there by letting a full stagger finish first. It then toggles enable B and enable C in turn, each while the switch is on. A gap without ticks is placed inside a pending stage delay, which shows that the count pauses rather than restarts. The bench sets short tick counts in the table so that every edge can be predicted exactly.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

    localparam int unsigned NUM_PG    = 4;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned NUM_CODES = 1 << SEL_W;
    localparam int unsigned CNT_W     = 18;

    typedef logic [NUM_CODES-1:0][CNT_W-1:0] dly_table_t;

    // Tick counts (microseconds) for codes 7 down to 0.
    localparam dly_table_t DEF_DLY_TICKS = {
        18'd160000, 18'd80000, 18'd20000, 18'd5000,
        18'd1000,   18'd500,   18'd100,   18'd50
    };

    typedef struct packed {
        logic en_a;
        logic en_b;
        logic en_c;
        logic fs_ok;
        logic fs_as_enable;
        logic pg1_gates_rest;
    } gate_in_t;

    function automatic logic tick_done(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] target);
        return ({1'b0, cnt} + 1'b1) >= {1'b0, target};
    endfunction

endpackage

// File: rtl/pg_enable_cascade.sv
module pg_enable_cascade
    import pg_seq_pkg::*;
(
    input  gate_in_t           gin,
    output logic [NUM_PG-1:0]  gate
);

    logic fs_group;

    always_comb begin
        fs_group = (gin.fs_as_enable && gin.pg1_gates_rest) ? gin.fs_ok : 1'b1;
        gate[0]  = !gin.fs_as_enable || gin.fs_ok;
        gate[1]  = gin.en_a && fs_group;
        gate[2]  = gate[1] && gin.en_b;
        gate[3]  = gate[2] && gin.en_c;
    end

    // A line's enable implies the enables of the lines that cover it.
    always_comb begin
        assert_nested_R8: assert (!(gate[3] && !gate[2]) && !(gate[2] && !gate[1]));
        assert_ena_R7:    assert (gin.en_a || gate[3:1] == '0);
    end

endmodule

// File: rtl/pg_stage_timer.sv
module pg_stage_timer
    import pg_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             armed,
    input  logic [CNT_W-1:0] target,
    output logic             fire
);

    logic [CNT_W-1:0] cnt;

    assign fire = armed && tick && tick_done(cnt, target);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= fire ? '0 : cnt + 1'b1;
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && !tick) |=> $stable(cnt));

    assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
        armed |-> ({1'b0, cnt} <= {1'b0, target} || target == '0 && cnt == '0));

endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
    import pg_seq_pkg::*;
#(
    parameter dly_table_t DLY_TICKS = DEF_DLY_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             us_tick,
    input  logic             switch_on,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             en_c,
    input  logic             fs_n,
    input  logic             fs_as_enable,
    input  logic             pg1_gates_rest,
    input  logic [SEL_W-1:0] dly_sel,
    output logic [NUM_PG-1:0] pg_n_o,
    output logic [NUM_PG-1:0] pg_oe_o
);

    gate_in_t          gin;
    logic [NUM_PG-1:0] gate;
    logic [NUM_PG-1:0] active;
    logic [NUM_PG-1:0] fire;
    logic [CNT_W-1:0]  target;

    always_comb begin
        gin.en_a           = en_a;
        gin.en_b           = en_b;
        gin.en_c           = en_c;
        gin.fs_ok          = fs_n;
        gin.fs_as_enable   = fs_as_enable;
        gin.pg1_gates_rest = pg1_gates_rest;
    end

    assign target = DLY_TICKS[dly_sel];

    pg_enable_cascade u_cascade (
        .gin  (gin),
        .gate (gate)
    );

    // Line 1 needs no delay; it follows permission and its own enable.
    assign fire[0] = switch_on && gate[0] && !active[0];

    generate
        for (genvar i = 1; i < NUM_PG; i++) begin : g_stage
            logic armed;
            assign armed = switch_on && active[i-1] && gate[i] && !active[i];

            pg_stage_timer u_timer (
                .clk    (clk),
                .rst    (rst),
                .tick   (us_tick),
                .armed  (armed),
                .target (target),
                .fire   (fire[i])
            );

            assert_gap_R3: assert property (@(posedge clk) disable iff (rst)
                $rose(active[i]) |-> $past(active[i-1]));

            if (i >= 2) begin : g_order
                assert_order_R9: assert property (@(posedge clk) disable iff (rst)
                    active[i] |-> active[i-1]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PG; i++) begin
            if (rst || !switch_on || !gate[i]) begin
                active[i] <= 1'b0;
            end else if (fire[i]) begin
                active[i] <= 1'b1;
            end
        end
    end

    assign pg_n_o  = ~(active & gate & {NUM_PG{switch_on}});
    assign pg_oe_o = gate;

    assert_off_R6: assert property (@(posedge clk) disable iff (rst)
        !switch_on |=> active == '0);

    assert_first_R2: assert property (@(posedge clk) disable iff (rst)
        (switch_on && gate[0] && !active[0]) |=> (active[0] || !switch_on || !gate[0]) || active[0]);

endmodule

// File: tb/pg_sequencer_tb.sv
module pg_sequencer_tb;
    import pg_seq_pkg::*;

    localparam dly_table_t TB_TICKS = {
        18'd9, 18'd8, 18'd7, 18'd6, 18'd5, 18'd4, 18'd3, 18'd2
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b1;
    logic switch_on = 1'b0;
    logic en_a = 1'b1, en_b = 1'b1, en_c = 1'b1;
    logic fs_n = 1'b1, fs_as_enable = 1'b0, pg1_gates_rest = 1'b0;
    logic [SEL_W-1:0] dly_sel = 3'd1;
    logic [NUM_PG-1:0] pg_n_o, pg_oe_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [3:0]  pg;
        logic [3:0]  oe;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pg_sequencer #(.DLY_TICKS(TB_TICKS)) u_dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .switch_on(switch_on),
        .en_a(en_a), .en_b(en_b), .en_c(en_c), .fs_n(fs_n),
        .fs_as_enable(fs_as_enable), .pg1_gates_rest(pg1_gates_rest),
        .dly_sel(dly_sel), .pg_n_o(pg_n_o), .pg_oe_o(pg_oe_o)
    );

    task automatic expect_at(input int at, input logic [3:0] pg,
                             input logic [3:0] oe, input string req);
        exp_t e;
        e.at = at; e.pg = pg; e.oe = oe; e.req = req;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compares queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (e.at < cyc) begin
                n_fail++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.at, cyc);
            end else if (pg_n_o !== e.pg || pg_oe_o !== e.oe) begin
                n_fail++;
                $display("FAIL %s @%0d: pg_n=%b oe=%b expected pg_n=%b oe=%b",
                         e.req, cyc, pg_n_o, pg_oe_o, e.pg, e.oe);
            end
        end
    end

    initial begin
        int t;
        step(3);
        t = cyc;
        expect_at(t, 4'hF, 4'hF, "R1");
        rst = 1'b0;
        expect_at(t + 2, 4'hF, 4'hF, "R1");
        step(3);

        // R2 / R3: full stagger with code 1 (3 ticks)
        t = cyc;
        expect_at(t,      4'hF, 4'hF, "R2");
        expect_at(t + 1,  4'hE, 4'hF, "R2");
        expect_at(t + 3,  4'hE, 4'hF, "R3");
        expect_at(t + 4,  4'hC, 4'hF, "R3");
        expect_at(t + 6,  4'hC, 4'hF, "R3");
        expect_at(t + 7,  4'h8, 4'hF, "R3");
        expect_at(t + 9,  4'h8, 4'hF, "R3");
        expect_at(t + 10, 4'h0, 4'hF, "R3");
        switch_on = 1'b1;
        step(12);

        // R12: fs_n ignored in normal mode
        t = cyc;
        expect_at(t,     4'h0, 4'hF, "R12");
        expect_at(t + 2, 4'h0, 4'hF, "R12");
        fs_n = 1'b0;
        step(3);
        fs_n = 1'b1;
        step(1);

        // R6: permission loss releases everything in the same cycle
        t = cyc;
        expect_at(t,     4'hF, 4'hF, "R6");
        expect_at(t + 2, 4'hF, 4'hF, "R6");
        switch_on = 1'b0;
        step(3);

        // R4 / R5: code 4 (6 ticks), then a 4-cycle tick gap in stage 3
        t = cyc;
        dly_sel = 3'd4;
        expect_at(t + 1,  4'hE, 4'hF, "R6");
        expect_at(t + 6,  4'hE, 4'hF, "R4");
        expect_at(t + 7,  4'hC, 4'hF, "R4");
        expect_at(t + 16, 4'hC, 4'hF, "R5");
        expect_at(t + 17, 4'h8, 4'hF, "R5");
        expect_at(t + 22, 4'h8, 4'hF, "R4");
        expect_at(t + 23, 4'h0, 4'hF, "R4");
        switch_on = 1'b1;
        step(8);
        us_tick = 1'b0;
        step(4);
        us_tick = 1'b1;
        step(13);

        // R7 / R9: enable A drop and restart (code 1)
        dly_sel = 3'd1;
        t = cyc;
        expect_at(t,     4'hF & 4'hE, 4'h1, "R7");
        expect_at(t + 2, 4'hE, 4'h1, "R7");
        en_a = 1'b0;
        step(3);
        t = cyc;
        expect_at(t,     4'hE, 4'hF, "R9");
        expect_at(t + 2, 4'hE, 4'hF, "R9");
        expect_at(t + 3, 4'hC, 4'hF, "R9");
        expect_at(t + 6, 4'h8, 4'hF, "R9");
        expect_at(t + 9, 4'h0, 4'hF, "R9");
        en_a = 1'b1;
        step(11);

        // R8 / R9: enable B, then enable C
        t = cyc;
        expect_at(t,      4'hC, 4'h3, "R8");
        expect_at(t + 3,  4'hC, 4'h7, "R8");
        expect_at(t + 5,  4'hC, 4'h7, "R9");
        expect_at(t + 6,  4'h8, 4'h7, "R9");
        expect_at(t + 8,  4'h8, 4'h7, "R8");
        expect_at(t + 11, 4'h8, 4'hF, "R9");
        expect_at(t + 12, 4'h0, 4'hF, "R9");
        en_b = 1'b0;
        step(3);
        en_b = 1'b1;
        en_c = 1'b0;
        step(6);
        en_c = 1'b1;
        step(5);

        // R10: fs_n as independent enable of line 1
        fs_as_enable = 1'b1;
        t = cyc;
        expect_at(t,     4'h1, 4'hE, "R10");
        expect_at(t + 2, 4'h1, 4'hE, "R10");
        expect_at(t + 3, 4'h1, 4'hF, "R10");
        expect_at(t + 4, 4'h0, 4'hF, "R10");
        fs_n = 1'b0;
        step(3);
        fs_n = 1'b1;
        step(3);

        // R11: fs_n gates every line
        pg1_gates_rest = 1'b1;
        t = cyc;
        expect_at(t,      4'hF, 4'h0, "R11");
        expect_at(t + 2,  4'hF, 4'h0, "R11");
        expect_at(t + 3,  4'hF, 4'hF, "R11");
        expect_at(t + 4,  4'hE, 4'hF, "R11");
        expect_at(t + 7,  4'hC, 4'hF, "R11");
        expect_at(t + 10, 4'h8, 4'hF, "R11");
        expect_at(t + 13, 4'h0, 4'hF, "R11");
        fs_n = 1'b0;
        step(3);
        fs_n = 1'b1;
        step(14);

        switch_on = 1'b0;
        while (sb.size() > 0) step(1);
        step(2);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule